// File: doc/BRIEF.md
# Next-PC Branch and Jump Unit

This block owns the program counter of a 32-bit RISC core with 4-byte, word-aligned instructions and works out, every cycle, where the next fetch comes from. It reads the current instruction's major opcode, its function code, and its 26-bit target field. The low 16 bits of that field serve as the branch offset. It also takes the value of the first source register and a single equality result from the datapath's comparator.

From these inputs it picks one of four successors: the sequential address, a PC-relative branch target, a page-local absolute jump target, or a register-held target. It also supplies the return address, with its write strobe, for the link register. The successor is visible combinationally on `pc_next`. It is committed to `pc_q` on a rising edge whenever the advance enable is high, so the fetch stage can stall the unit simply by dropping that enable.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `pc_q` is loaded with the parameter `START_PC`, whatever the other inputs are.
- R2: With `rst_n` high and `adv_en` low, `pc_q` keeps its value across the edge and `link_we` stays 0.
- R3: Any `op_code` other than 000010, 000011, 000100 and 000101, and any `op_code` 000000 with `func_code` other than 001000, yields `pc_next = pc_q + 4`. This covers register-format arithmetic and loads.
- R4: With `op_code` 000100 (branch if equal) and `eq_flag` = 1, `pc_next = pc_q + 4 + (sign-extended tgt_field[15:0] << 2)`. Negative offsets move backwards.
- R5: With `op_code` 000101 (branch if not equal) and `eq_flag` = 0, `pc_next` is the same relative target as in R4.
- R6: A branch whose condition fails (000100 with `eq_flag` 0, or 000101 with `eq_flag` 1) yields `pc_next = pc_q + 4`.
- R7: With `op_code` 000010, `pc_next = {pc_q[31:28], tgt_field, 2'b00}`. The current 256 MB page is kept.
- R8: With `op_code` 000011, `pc_next` is the R7 target, `link_val = pc_q + 4`, and `link_we` equals `adv_en`. This value is meant for register 31. For every other opcode `link_we` is 0.
- R9: With `op_code` 000000 and `func_code` 001000, `pc_next = {rs_value[31:2], 2'b00}`, and `align_err` is 1 exactly when `rs_value[1:0]` is non-zero. For every other instruction `align_err` is 0.
- R10: When `adv_en` is high at an edge, `pc_q` takes the value `pc_next` showed before that edge. `pc_q[1:0]` is always 00.
- R11: The sequential increment wraps modulo 2^32, so `pc_q` = 0xFFFFFFFC steps to 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv_en | input | 1 | Commit `pc_next` into `pc_q` at this edge |
| op_code | input | 6 | Major opcode of the current instruction |
| func_code | input | 6 | Function code of a register-format instruction |
| tgt_field | input | 26 | Jump target; low 16 bits are the branch offset |
| rs_value | input | 32 | Value of the first source register |
| eq_flag | input | 1 | Datapath comparator: the two source registers are equal |
| pc_q | output | 32 | Current program counter |
| pc_next | output | 32 | Address that the next enabled edge loads |
| link_val | output | 32 | Return address (`pc_q + 4`) |
| link_we | output | 1 | Write strobe for the return-address register |
| align_err | output | 1 | Register-held target was not word aligned |

## Verification
The bench builds the unit with `START_PC` = 0x0FFFFFF8, two words below a 256 MB page boundary. With that start, plain sequential flow crosses into page 1 within two steps, so the page bits that the absolute jumps keep come from a counter that has just carried rather than from zeros. A register jump to 0xFFFFFFFF then brings the top of the address space within reach. That single stimulus covers the alignment flag, the clearing of the low bits and the wrap to zero. The other parameters keep their 32-bit, 16-bit-offset and 26-bit-target defaults, because the opcode-level encodings depend on them.

// File: rtl/npc_pkg.sv
// Package: shared opcode encodings and the control-flow classification
// used by the next-PC unit. Assumes the 6-bit major opcode and function code
// of a classic three-format RISC encoding.
package npc_pkg;
    localparam int OP_W = 6;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;
    localparam logic [OP_W-1:0] OPC_JLINK = 6'b000011;
    localparam logic [OP_W-1:0] OPC_BREQ  = 6'b000100;
    localparam logic [OP_W-1:0] OPC_BRNE  = 6'b000101;
    localparam logic [OP_W-1:0] FN_JREG   = 6'b001000;

    // Kind of successor the current instruction asks for
    typedef enum logic [2:0] {
        FLOW_SEQ  = 3'd0,
        FLOW_BREQ = 3'd1,
        FLOW_BRNE = 3'd2,
        FLOW_JUMP = 3'd3,
        FLOW_JLNK = 3'd4,
        FLOW_JREG = 3'd5
    } flow_kind_e;
endpackage

// File: rtl/npc_decode.sv
// Module: npc_decode
// Classifies the current instruction into a flow kind. Pure combinational.
// Assumes the opcode/function-code values held in npc_pkg; anything not
// recognised is treated as sequential flow.
module npc_decode
    import npc_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    input  logic [OP_W-1:0] func_code,
    output flow_kind_e      kind
);
    // Map opcode (and function code for register format) to a flow kind
    always_comb begin
        unique case (op_code)
            OPC_BREQ:  kind = FLOW_BREQ;
            OPC_BRNE:  kind = FLOW_BRNE;
            OPC_JUMP:  kind = FLOW_JUMP;
            OPC_JLINK: kind = FLOW_JLNK;
            OPC_RTYPE: kind = (func_code == FN_JREG) ? FLOW_JREG : FLOW_SEQ;
            default:   kind = FLOW_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
// Module: npc_target
// Builds every candidate successor address from the current PC and picks one
// according to the flow kind and the equality flag. Also produces the return
// address and the misalignment flag for register-held targets.
// Assumes ADDR_W = TGT_W + 2 + page bits and OFS_W <= TGT_W.
module npc_target
    import npc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TGT_W  = 26,
    parameter int OFS_W  = 16
) (
    input  logic [ADDR_W-1:0] pc_cur,
    input  flow_kind_e        kind,
    input  logic              eq_flag,
    input  logic [TGT_W-1:0]  tgt_field,
    input  logic [ADDR_W-1:0] rs_value,
    output logic [ADDR_W-1:0] pc_next,
    output logic [ADDR_W-1:0] ret_addr,
    output logic              misalign
);
    localparam int ALIGN_W = 2;
    localparam int PAGE_W  = ADDR_W - TGT_W - ALIGN_W;
    localparam int SEXT_W  = ADDR_W - OFS_W - ALIGN_W;
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] rel_ofs;
    logic [ADDR_W-1:0] rel_addr;
    logic [ADDR_W-1:0] page_addr;
    logic [ADDR_W-1:0] reg_addr;
    logic              rel_take;

    // Candidate addresses: sequential, PC-relative, page-local, register
    always_comb begin
        seq_addr  = pc_cur + WORD_STEP;
        rel_ofs   = {{SEXT_W{tgt_field[OFS_W-1]}}, tgt_field[OFS_W-1:0], {ALIGN_W{1'b0}}};
        rel_addr  = seq_addr + rel_ofs;
        page_addr = {pc_cur[ADDR_W-1 -: PAGE_W], tgt_field, {ALIGN_W{1'b0}}};
        reg_addr  = {rs_value[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    end

    // Branch condition: equal-branch wants eq_flag, not-equal wants its inverse
    always_comb begin
        rel_take = ((kind == FLOW_BREQ) &&  eq_flag) ||
                   ((kind == FLOW_BRNE) && !eq_flag);
    end

    // Successor select
    always_comb begin
        unique case (kind)
            FLOW_BREQ, FLOW_BRNE: pc_next = rel_take ? rel_addr : seq_addr;
            FLOW_JUMP, FLOW_JLNK: pc_next = page_addr;
            FLOW_JREG:            pc_next = reg_addr;
            default:              pc_next = seq_addr;
        endcase
    end

    // Return address and misalignment report
    always_comb begin
        ret_addr = seq_addr;
        misalign = (kind == FLOW_JREG) && (rs_value[ALIGN_W-1:0] != '0);
    end
endmodule

// File: rtl/npc_pcreg.sv
// Module: npc_pcreg
// The program-counter register: synchronous active-low reset to START_PC,
// otherwise loads the offered successor when the advance enable is high.
// Assumes START_PC is word aligned.
module npc_pcreg #(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] START_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_en,
    input  logic [ADDR_W-1:0] pc_d,
    output logic [ADDR_W-1:0] pc_q
);
    // PC state update
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= START_PC;
        else if (adv_en)
            pc_q <= pc_d;
    end

    assert_reset_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> pc_q == START_PC)
        else $error("pc not at start address after reset");

    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(adv_en)) |-> pc_q == $past(pc_q))
        else $error("pc moved while stalled");

    assert_commit_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(adv_en)) |-> pc_q == $past(pc_d))
        else $error("pc did not take offered successor");

    assert_word_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pc_q[1:0] == 2'b00)
        else $error("pc low bits not zero");
endmodule

// File: rtl/npc_unit.sv
// Module: npc_unit (top)
// Next-fetch-address unit: decodes the flow kind, builds the successor and
// return address, and holds the PC. Assumes one instruction per cycle while
// adv_en is high and a word-aligned START_PC.
module npc_unit
    import npc_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                TGT_W    = 26,
    parameter int                OFS_W    = 16,
    parameter logic [ADDR_W-1:0] START_PC = 32'h0040_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_en,
    input  logic [OP_W-1:0]   op_code,
    input  logic [OP_W-1:0]   func_code,
    input  logic [TGT_W-1:0]  tgt_field,
    input  logic [ADDR_W-1:0] rs_value,
    input  logic              eq_flag,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] pc_next,
    output logic [ADDR_W-1:0] link_val,
    output logic              link_we,
    output logic              align_err
);
    localparam int PAGE_HI = ADDR_W - 1;
    localparam int PAGE_LO = TGT_W + 2;

    flow_kind_e kind;

    npc_decode u_decode (
        .op_code   (op_code),
        .func_code (func_code),
        .kind      (kind)
    );

    npc_target #(
        .ADDR_W (ADDR_W),
        .TGT_W  (TGT_W),
        .OFS_W  (OFS_W)
    ) u_target (
        .pc_cur    (pc_q),
        .kind      (kind),
        .eq_flag   (eq_flag),
        .tgt_field (tgt_field),
        .rs_value  (rs_value),
        .pc_next   (pc_next),
        .ret_addr  (link_val),
        .misalign  (align_err)
    );

    npc_pcreg #(
        .ADDR_W   (ADDR_W),
        .START_PC (START_PC)
    ) u_pcreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_en (adv_en),
        .pc_d   (pc_next),
        .pc_q   (pc_q)
    );

    // Link strobe: only a committed jump-and-link writes the return register
    always_comb begin
        link_we = adv_en && (kind == FLOW_JLNK);
    end

    assert_link_only_jal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (op_code == OPC_JLINK && adv_en))
        else $error("link strobe outside jump-and-link");

    assert_jump_page_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && (op_code == OPC_JUMP || op_code == OPC_JLINK))
            |=> pc_q[PAGE_HI:PAGE_LO] == $past(pc_q[PAGE_HI:PAGE_LO]))
        else $error("jump left the current page");

    assert_jreg_misalign_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OPC_RTYPE && func_code == FN_JREG && rs_value[1:0] != 2'b00)
            |-> (align_err && pc_next[1:0] == 2'b00))
        else $error("misaligned register target not flagged or not cleared");
endmodule

// File: tb/npc_unit_tb.sv
// Bench for npc_unit: a driver task applies one instruction per cycle, checks
// the combinational outputs, and queues the expected post-edge PC; a monitor
// pops the queue after each rising edge and compares.
module npc_unit_tb_top;
    localparam logic [31:0] START = 32'h0FFF_FFF8;

    typedef struct {
        logic [31:0] pc;
        string       tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv_en = 1'b0;
    logic [5:0]  op_code = '0;
    logic [5:0]  func_code = '0;
    logic [25:0] tgt_field = '0;
    logic [31:0] rs_value = '0;
    logic        eq_flag = 1'b0;
    logic [31:0] pc_q, pc_next, link_val;
    logic        link_we, align_err;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] m_pc;
    exp_item_t sb_q[$];
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    npc_unit #(.START_PC(START)) dut_i (
        .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .op_code(op_code),
        .func_code(func_code), .tgt_field(tgt_field), .rs_value(rs_value),
        .eq_flag(eq_flag), .pc_q(pc_q), .pc_next(pc_next),
        .link_val(link_val), .link_we(link_we), .align_err(align_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference successor computed from the requirement text
    function automatic logic [31:0] ref_next(input logic [31:0] pc, input logic [5:0] op,
                                             input logic [5:0] fn, input logic [25:0] tg,
                                             input logic [31:0] rs, input logic eq);
        logic [31:0] seq;
        logic [31:0] ofs;
        seq = pc + 32'd4;
        ofs = {{14{tg[15]}}, tg[15:0], 2'b00};
        case (op)
            6'b000100: return eq ? seq + ofs : seq;
            6'b000101: return eq ? seq : seq + ofs;
            6'b000010, 6'b000011: return {pc[31:28], tg, 2'b00};
            6'b000000: return (fn == 6'b001000) ? {rs[31:2], 2'b00} : seq;
            default:   return seq;
        endcase
    endfunction

    task automatic do_reset(input string tag);
        exp_item_t it;
        @(negedge clk);
        rst_n  = 1'b0;
        adv_en = 1'b1;
        op_code = 6'b000010;
        tgt_field = 26'h3FF_FFFF;
        it.pc = START; it.tag = tag;
        sb_q.push_back(it);
        m_pc = START;
        @(negedge clk);
        rst_n = 1'b1;
        adv_en = 1'b0;
    endtask

    task automatic step(input string tag, input logic adv, input logic [5:0] op,
                        input logic [5:0] fn, input logic [25:0] tg,
                        input logic [31:0] rs, input logic eq);
        exp_item_t it;
        logic [31:0] nx;
        logic        is_jal, is_jr;
        @(negedge clk);
        adv_en = adv; op_code = op; func_code = fn;
        tgt_field = tg; rs_value = rs; eq_flag = eq;
        nx = ref_next(m_pc, op, fn, tg, rs, eq);
        is_jal = (op == 6'b000011);
        is_jr  = (op == 6'b000000) && (fn == 6'b001000);
        #1;
        check({tag, " pc_next"}, pc_next, nx);
        check({tag, " link_we (R8)"}, {31'd0, link_we}, {31'd0, adv && is_jal});
        if (is_jal) check({tag, " link_val (R8)"}, link_val, m_pc + 32'd4);
        check({tag, " align_err (R9)"}, {31'd0, align_err},
              {31'd0, is_jr && (rs[1:0] != 2'b00)});
        it.pc = adv ? nx : m_pc;
        it.tag = tag;
        sb_q.push_back(it);
        m_pc = it.pc;
    endtask

    // Monitor: compare committed PC with queued expectation after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                check({it.tag, " pc_q (R10)"}, pc_q, it.pc);
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset("R1 initial reset");
        step("R3 seq add", 1, 6'b000000, 6'b100000, 26'h0, 32'h0, 0);      // 0FFFFFFC
        step("R3 seq page carry", 1, 6'b000000, 6'b100010, 26'h0, 32'h0, 1); // 10000000
        step("R2 stall beq", 0, 6'b000100, 6'b0, 26'd25, 32'h0, 1);
        step("R2 stall jal", 0, 6'b000011, 6'b0, 26'h12, 32'h0, 0);
        step("R4 beq taken +25", 1, 6'b000100, 6'b0, 26'd25, 32'h0, 1);     // 10000068
        step("R6 beq not taken", 1, 6'b000100, 6'b0, 26'd25, 32'h0, 0);
        step("R5 bne taken -2", 1, 6'b000101, 6'b0, 26'h0FFFE, 32'h0, 0);
        step("R6 bne not taken", 1, 6'b000101, 6'b0, 26'h0FFFE, 32'h0, 1);
        step("R4 beq taken backwards", 1, 6'b000100, 6'b0, 26'h38000, 32'h0, 1);
        step("R7 jump", 1, 6'b000010, 6'b0, 26'h0000010, 32'h0, 0);
        step("R7 jump max field", 1, 6'b000010, 6'b0, 26'h3FFFFFF, 32'h0, 1);
        step("R8 jal", 1, 6'b000011, 6'b0, 26'h0000100, 32'h0, 0);
        step("R9 jr aligned", 1, 6'b000000, 6'b001000, 26'h0, 32'h0040_0020, 0);
        step("R3 load op", 1, 6'b100011, 6'b001000, 26'h3FFFFFF, 32'h0, 1);
        step("R9 jr misaligned", 1, 6'b000000, 6'b001000, 26'h0, 32'hFFFF_FFFF, 0);
        step("R11 wrap", 1, 6'b000000, 6'b000000, 26'h0, 32'h0, 0);          // 00000000
        step("R3 other func", 1, 6'b000000, 6'b001001, 26'h0, 32'h1234_5671, 0);
        step("R8 jal second", 1, 6'b000011, 6'b0, 26'h2AAAAAA, 32'h0, 1);
        do_reset("R1 reset mid-run");
        step("R3 after reset", 1, 6'b001000, 6'b0, 26'h0, 32'h0, 0);
        @(negedge clk);
        adv_en = 1'b0;
        repeat (3) @(negedge clk);
        n_chk++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R10 scoreboard drain: actual %0d expected 0", sb_q.size());
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule